// File: doc/BRIEF.md
# Leveled Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt lines and a software interrupt register into one interrupt request for a processor. Each source carries a programmable 6-bit priority level, an NMI request bit and a register-set number. The block ORs the hardware lines with the software bits and masks the result with an enable register. Among the remaining pending sources it picks the one with the highest level. A source whose level is zero never wins.

For the winning source the block computes a handler address. This is the source index times a configurable vector-entry size, plus a table base. It presents that address, together with the source's register set, level and NMI flag, as a registered request packet, and raises an interrupt output. Software reaches all state through a word-indexed 32-bit CSR port with separate read and write strobes. Interrupt lines cross into the clock domain through a two-flop synchronizer.

Top module: `vic_lvl_top`

## Requirements
- R1: After reset every register reads 0, the interrupt output is low and the packet is all zero. A read of an undefined index (44 to 63) returns 0.
- R2: Per-source word i (index 0 to 31) holds level in bits [5:0], NMI request in bit [6] and register set in bits [12:7]. It reads back bits [12:0] of the last write, with the upper bits 0.
- R3: The pending value at index 35 equals (raw status OR software register at 37) AND enable at 32.
- R4: The winner is the pending source with the strictly greatest level. On equal levels the lowest index wins. A level of 0 never wins.
- R5: The config word at index 40 keeps bits [2:0] and reads the rest as 0. The handler address is the winner index times (4 << config[2:0]), plus the base at index 42, modulo 2^32.
- R6: With a winner, status at index 41 reads the winner index with bit 31 set. Index 43 and the packet address carry the handler address. The packet level, register set and NMI come from the winner, and the interrupt output is high. Without a winner, status, index 43, the whole packet and the output are 0.
- R7: Writes to 32 and 37 replace the value. Writes to 33 and 38 OR into enable and software. Writes to 34 and 39 clear the bits set in the data. A write to 42 replaces the base.
- R8: Writes to indices 35, 36, 41, 43 and 44 to 63 change no state and give a one-cycle error pulse in the cycle after the write. A valid write gives no pulse.
- R9: Raw status (index 36) follows the input lines through a two-flop synchronizer. The packet and interrupt output change exactly one clock after the register change that causes them.
- R10: Read data appears on the read-data port in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| csr_idx | input | 6 | CSR word index |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| csr_err | output | 1 | Pulse for a write to a read-only or undefined index |
| req_valid | output | 1 | Interrupt request to the processor |
| req_addr | output | 32 | Handler address of the winner |
| req_rs | output | 6 | Register set of the winner |
| req_lvl | output | 6 | Level of the winner |
| req_nmi | output | 1 | NMI flag of the winner |

## Verification
Ties are the hardest case to reach from the ports. They need many sources pending at once with identical nonzero levels. A case where every pending source has level zero also needs deliberate setup. Random sweeps drawing levels from only 0 to 3 produce many ties and all-zero cases. Directed passes add a full tie on all 32 sources, followed by masking the lowest winner, and an all-zero-level pass with every source pending.

// File: rtl/vic_lvl_pkg.sv
package vic_lvl_pkg;
  localparam int DW     = 32;
  localparam int AW     = 6;
  localparam int LVL_W  = 6;
  localparam int RS_W   = 6;
  localparam int CFG_W  = LVL_W + 1 + RS_W;
  localparam int SZ_W   = 3;

  localparam logic [AW-1:0] IX_EN      = 6'd32;
  localparam logic [AW-1:0] IX_EN_SET  = 6'd33;
  localparam logic [AW-1:0] IX_EN_CLR  = 6'd34;
  localparam logic [AW-1:0] IX_PEND    = 6'd35;
  localparam logic [AW-1:0] IX_RAW     = 6'd36;
  localparam logic [AW-1:0] IX_SW      = 6'd37;
  localparam logic [AW-1:0] IX_SW_SET  = 6'd38;
  localparam logic [AW-1:0] IX_SW_CLR  = 6'd39;
  localparam logic [AW-1:0] IX_CTL     = 6'd40;
  localparam logic [AW-1:0] IX_STAT    = 6'd41;
  localparam logic [AW-1:0] IX_BASE    = 6'd42;
  localparam logic [AW-1:0] IX_VADDR   = 6'd43;

  typedef struct packed {
    logic [RS_W-1:0]  rs;
    logic             nmi;
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  function automatic logic [DW-1:0] handler_addr(input logic [DW-1:0] idx,
                                                 input logic [SZ_W-1:0] sz,
                                                 input logic [DW-1:0] base);
    return (idx << (2 + int'(sz))) + base;
  endfunction

  function automatic logic [DW-1:0] merge_set(input logic [DW-1:0] cur, input logic [DW-1:0] v);
    return cur | v;
  endfunction

  function automatic logic [DW-1:0] merge_clr(input logic [DW-1:0] cur, input logic [DW-1:0] v);
    return cur & ~v;
  endfunction
endpackage

// File: rtl/vic_lvl_sync.sv
module vic_lvl_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vic_lvl_regs.sv
module vic_lvl_regs
  import vic_lvl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         idx,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [DW-1:0]         wdata,
  input  logic [NSRC-1:0]       raw,
  input  logic [DW-1:0]         stat_q,
  input  logic [DW-1:0]         vaddr_q,
  output src_cfg_t [NSRC-1:0]   cfg,
  output logic [NSRC-1:0]       pend,
  output logic [SZ_W-1:0]       ctl_sz,
  output logic [DW-1:0]         base,
  output logic [DW-1:0]         rdata,
  output logic                  err
);
  logic [NSRC-1:0] en_q, sw_q;
  logic            is_src, wr_bad;
  logic [DW-1:0]   rmux;

  assign is_src = (idx < AW'(NSRC));
  assign pend   = (raw | sw_q) & en_q;

  always_comb begin
    wr_bad = 1'b0;
    if (!is_src) begin
      unique case (idx)
        IX_EN, IX_EN_SET, IX_EN_CLR, IX_SW, IX_SW_SET, IX_SW_CLR, IX_CTL, IX_BASE: wr_bad = 1'b0;
        default: wr_bad = (idx >= 6'd32);
      endcase
    end
  end

  always_comb begin
    rmux = '0;
    if (is_src) rmux = DW'(cfg[idx[IW-1:0]]);
    else begin
      case (idx)
        IX_EN:    rmux = DW'(en_q);
        IX_PEND:  rmux = DW'(pend);
        IX_RAW:   rmux = DW'(raw);
        IX_SW:    rmux = DW'(sw_q);
        IX_CTL:   rmux = DW'(ctl_sz);
        IX_STAT:  rmux = stat_q;
        IX_BASE:  rmux = base;
        IX_VADDR: rmux = vaddr_q;
        default:  rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; en_q <= '0; sw_q <= '0; ctl_sz <= '0; base <= '0;
      rdata <= '0; err <= 1'b0;
    end else begin
      err <= wr & wr_bad;
      if (rd) rdata <= rmux;
      if (wr) begin
        if (is_src) cfg[idx[IW-1:0]] <= src_cfg_t'(wdata[CFG_W-1:0]);
        else begin
          case (idx)
            IX_EN:     en_q   <= wdata[NSRC-1:0];
            IX_EN_SET: en_q   <= NSRC'(merge_set(DW'(en_q), wdata));
            IX_EN_CLR: en_q   <= NSRC'(merge_clr(DW'(en_q), wdata));
            IX_SW:     sw_q   <= wdata[NSRC-1:0];
            IX_SW_SET: sw_q   <= NSRC'(merge_set(DW'(sw_q), wdata));
            IX_SW_CLR: sw_q   <= NSRC'(merge_clr(DW'(sw_q), wdata));
            IX_CTL:    ctl_sz <= wdata[SZ_W-1:0];
            IX_BASE:   base   <= wdata;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/vic_lvl_arb.sv
module vic_lvl_arb
  import vic_lvl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]     pend,
  input  src_cfg_t [NSRC-1:0] cfg,
  output logic                win_vld,
  output logic [IW-1:0]       win_idx,
  output logic [LVL_W-1:0]    win_lvl
);
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (cfg[i].lvl > win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IW'(i);
        win_lvl = cfg[i].lvl;
      end
    end
  end
endmodule

// File: rtl/vic_lvl_top.sv
module vic_lvl_top
  import vic_lvl_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [AW-1:0]     csr_idx,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [DW-1:0]     csr_wdata,
  output logic [DW-1:0]     csr_rdata,
  output logic              csr_err,
  output logic              req_valid,
  output logic [DW-1:0]     req_addr,
  output logic [RS_W-1:0]   req_rs,
  output logic [LVL_W-1:0]  req_lvl,
  output logic              req_nmi
);
  logic [NSRC-1:0]     raw_w, pend_w;
  src_cfg_t [NSRC-1:0] cfg_w;
  logic [SZ_W-1:0]     sz_w;
  logic [DW-1:0]       base_w, stat_q;
  logic                win_vld_w;
  logic [IW-1:0]       win_idx_w;
  logic [LVL_W-1:0]    win_lvl_w;
  logic [DW-1:0]       haddr_w;

  vic_lvl_sync #(.W(NSRC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(raw_w)
  );

  vic_lvl_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx(csr_idx), .wr(csr_wr), .rd(csr_rd),
    .wdata(csr_wdata), .raw(raw_w), .stat_q(stat_q), .vaddr_q(req_addr),
    .cfg(cfg_w), .pend(pend_w), .ctl_sz(sz_w), .base(base_w),
    .rdata(csr_rdata), .err(csr_err)
  );

  vic_lvl_arb #(.NSRC(NSRC)) u_arb (
    .pend(pend_w), .cfg(cfg_w), .win_vld(win_vld_w),
    .win_idx(win_idx_w), .win_lvl(win_lvl_w)
  );

  assign haddr_w = handler_addr(DW'(win_idx_w), sz_w, base_w);

  always_ff @(posedge clk) begin
    if (!rst_n || !win_vld_w) begin
      req_valid <= 1'b0; req_addr <= '0; req_rs <= '0;
      req_lvl <= '0; req_nmi <= 1'b0; stat_q <= '0;
    end else begin
      req_valid <= 1'b1;
      req_addr  <= haddr_w;
      req_rs    <= cfg_w[win_idx_w].rs;
      req_lvl   <= win_lvl_w;
      req_nmi   <= cfg_w[win_idx_w].nmi;
      stat_q    <= {1'b1, (DW-1)'(win_idx_w)};
    end
  end
endmodule

// File: rtl/vic_lvl_chk.sv
module vic_lvl_chk
  import vic_lvl_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_wr,
  input logic             csr_err,
  input logic             req_valid,
  input logic [DW-1:0]    req_addr,
  input logic [RS_W-1:0]  req_rs,
  input logic [LVL_W-1:0] req_lvl,
  input logic             req_nmi,
  input logic [NSRC-1:0]  pend_w,
  input logic             win_vld_w
);
  AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_lvl != '0));                                            // R4
  AST_IDLE_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_addr == '0 && req_rs == '0 && req_lvl == '0 && !req_nmi)); // R6
  AST_NO_PEND_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w == '0) |=> !req_valid);                                             // R3
  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |-> $past(csr_wr));                                                 // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |=> (!csr_err || $past(csr_wr)));                                   // R8
  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_w |=> req_valid);                                                   // R9
endmodule

bind vic_lvl_top vic_lvl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_err(csr_err),
  .req_valid(req_valid), .req_addr(req_addr), .req_rs(req_rs),
  .req_lvl(req_lvl), .req_nmi(req_nmi), .pend_w(pend_w), .win_vld_w(win_vld_w)
);

// File: tb/sim_vic_lvl_top.sv
module sim_vic_lvl_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [5:0]  csr_idx = '0;
  logic        csr_wr = 1'b0, csr_rd = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_err;
  logic        req_valid, req_nmi;
  logic [31:0] req_addr;
  logic [5:0]  req_rs, req_lvl;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [12:0] m_cfg [N];
  logic [31:0] m_en, m_sw, m_base;
  logic [2:0]  m_sz;
  logic        last_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_lvl_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .csr_idx(csr_idx),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_err(csr_err), .req_valid(req_valid),
    .req_addr(req_addr), .req_rs(req_rs), .req_lvl(req_lvl), .req_nmi(req_nmi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] i, input logic [31:0] d);
    @(negedge clk);
    csr_idx = i; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
    last_err = csr_err;
    if (i < 6'd32) m_cfg[i] = d[12:0];
    case (i)
      6'd32: m_en = d;
      6'd33: m_en = m_en | d;
      6'd34: m_en = m_en & ~d;
      6'd37: m_sw = d;
      6'd38: m_sw = m_sw | d;
      6'd39: m_sw = m_sw & ~d;
      6'd40: m_sz = d[2:0];
      6'd42: m_base = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [5:0] i, output logic [31:0] v);
    @(negedge clk);
    csr_idx = i; csr_rd = 1'b1;
    @(negedge clk);
    csr_rd = 1'b0;
    v = csr_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic int model_win(input logic [31:0] raw);
    logic [31:0] p;
    int best, w;
    p = (raw | m_sw) & m_en;
    best = 0; w = -1;
    for (int i = 0; i < N; i++)
      if (p[i] && int'(m_cfg[i][5:0]) > best) begin best = int'(m_cfg[i][5:0]); w = i; end
    return w;
  endfunction

  task automatic check_pkt(input string tag);
    int w;
    logic [31:0] ea, v;
    w = model_win(irq_in);
    if (w < 0) begin
      check({tag, " R6 valid"}, {31'd0, req_valid}, 32'd0);
      check({tag, " R6 addr"}, req_addr, 32'd0);
      rd(6'd41, v); check({tag, " R6 status"}, v, 32'd0);
    end else begin
      ea = 32'(w) * (32'd4 << m_sz) + m_base;
      check({tag, " R4 valid"}, {31'd0, req_valid}, 32'd1);
      check({tag, " R5 addr"}, req_addr, ea);
      check({tag, " R4 lvl"}, {26'd0, req_lvl}, {26'd0, m_cfg[w][5:0]});
      check({tag, " R6 rs"}, {26'd0, req_rs}, {26'd0, m_cfg[w][12:7]});
      check({tag, " R6 nmi"}, {31'd0, req_nmi}, {31'd0, m_cfg[w][6]});
      rd(6'd41, v); check({tag, " R6 status"}, v, 32'h8000_0000 | 32'(w));
      rd(6'd43, v); check({tag, " R6 vaddr"}, v, ea);
    end
    rd(6'd35, v); check({tag, " R3 pending"}, v, (irq_in | m_sw) & m_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  ro_list [8];
    for (int i = 0; i < N; i++) m_cfg[i] = '0;
    m_en = '0; m_sw = '0; m_base = '0; m_sz = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 valid", {31'd0, req_valid}, 32'd0);
    check("R1 addr", req_addr, 32'd0);
    foreach (ro_list[k]) ro_list[k] = '0;
    for (int i = 0; i < 64; i += 3) begin rd(6'(i), v); check("R1 reset read", v, 32'd0); end
    rd(6'd63, v); check("R1 undefined read", v, 32'd0);

    // R2 field storage, R10 read latency
    wr(6'd5, 32'hFFFF_FFFF); rd(6'd5, v); check("R2 cfg readback", v, 32'h0000_1FFF);
    wr(6'd5, 32'h0); rd(6'd5, v); check("R10 read data", v, 32'h0);

    // R5 size field
    wr(6'd40, 32'hFFFF_FFFE); rd(6'd40, v); check("R5 ctl keeps [2:0]", v, 32'd6);
    wr(6'd40, 32'd0);

    // R7 set/clear semantics
    wr(6'd32, 32'h0000_0F0F); wr(6'd33, 32'h0000_F000); wr(6'd34, 32'h0000_0F00);
    rd(6'd32, v); check("R7 enable set/clr", v, 32'h0000_F00F);
    wr(6'd37, 32'h00FF_0000); wr(6'd38, 32'h0000_0001); wr(6'd39, 32'h0001_0000);
    rd(6'd37, v); check("R7 sw set/clr", v, 32'h00FE_0001);
    wr(6'd42, 32'h1234_5678); rd(6'd42, v); check("R7 base write", v, 32'h1234_5678);
    check("R8 valid write no err", {31'd0, last_err}, 32'd0);

    // R8 read-only/undefined writes
    ro_list[0] = 6'd35; ro_list[1] = 6'd36; ro_list[2] = 6'd41; ro_list[3] = 6'd43;
    ro_list[4] = 6'd44; ro_list[5] = 6'd50; ro_list[6] = 6'd63; ro_list[7] = 6'd47;
    foreach (ro_list[k]) begin
      wr(ro_list[k], 32'hFFFF_FFFF);
      check("R8 err pulse", {31'd0, last_err}, 32'd1);
      @(negedge clk); check("R8 err one cycle", {31'd0, csr_err}, 32'd0);
    end
    rd(6'd36, v); check("R8 raw untouched", v, 32'd0);
    rd(6'd41, v); check("R8 status untouched", v, 32'd0);
    rd(6'd37, v); check("R8 sw untouched", v, 32'h00FE_0001);

    // R9 raw follows inputs; output one clock after register change
    wr(6'd32, 32'd0); wr(6'd37, 32'd0); wr(6'd42, 32'd0);
    @(negedge clk); irq_in = 32'hA5A5_0033;
    settle(); rd(6'd36, v); check("R9 raw status", v, 32'hA5A5_0033);
    irq_in = '0; settle();
    wr(6'd9, 32'h0000_0002);
    wr(6'd37, 32'h0000_0200);
    wr(6'd32, 32'h0000_0200);
    check("R9 no change at write edge", {31'd0, req_valid}, 32'd0);
    @(negedge clk); check("R9 output one clock later", {31'd0, req_valid}, 32'd1);
    wr(6'd32, 32'd0); wr(6'd37, 32'd0); settle();

    // R4/R5/R6 single-source sweep with varying size and base
    for (int i = 0; i < N; i++) begin
      wr(6'(i), {19'd0, 6'(i ^ 5'h15), 1'(i & 1), 6'(i + 1)});
      wr(6'd40, 32'(i % 8));
      wr(6'd42, 32'h0100_0000 + 32'(i * 64));
      wr(6'd37, 32'd1 << i);
      wr(6'd32, 32'hFFFF_FFFF);
      settle(); check_pkt("sweep");
    end

    // R4 full tie: lowest index wins, then next after masking
    for (int i = 0; i < N; i++) wr(6'(i), 32'h0000_0003 | (32'(i) << 7));
    wr(6'd37, 32'hFFFF_FFFF); wr(6'd32, 32'hFFFF_FFFF); settle();
    check("R4 tie lowest", {26'd0, req_rs}, 32'd0);
    check_pkt("tie");
    wr(6'd34, 32'h0000_0001); settle();
    check("R4 tie next", {26'd0, req_rs}, 32'd1);
    check_pkt("tie masked");

    // R4 all-zero levels: no winner
    for (int i = 0; i < N; i++) wr(6'(i), 32'h0000_1F80);
    settle(); check_pkt("zero level");

    // random sweep with small level range to force ties
    wr(6'd37, 32'd0);
    for (int it = 0; it < 250; it++) begin
      for (int i = 0; i < N; i++)
        wr(6'(i), {19'd0, 6'($urandom), 1'($urandom), 6'($urandom_range(0, 3))});
      wr(6'd32, $urandom); wr(6'd37, $urandom & $urandom);
      wr(6'd40, $urandom); wr(6'd42, $urandom);
      @(negedge clk); irq_in = $urandom;
      settle(); check_pkt("random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule